// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

This block screens a byte-wide MPEG transport stream packet by packet. Each packet is `PKT_LEN` bytes long (188 by default) and begins with a byte marked by `in_sop`. The block packs the first eight bytes of each packet into a 64-bit header word, with the first byte as the most significant. It cuts a configurable bit field out of that word to form the packet identifier (PID). The PID indexes a one-bit-per-PID table of 8192 entries held in internal registers. A packet whose table bit is 1 is forwarded. Any other packet is discarded.

The keep/drop decision is available once the header is in, but the packet may still be cut short by a new start marker. The block therefore stores each packet in a ring buffer and releases it only after its last byte has arrived and the packet was accepted. The output is a byte stream of whole accepted packets, each marked by `out_sop` on its first byte.

Software-side logic updates the table through a small write port. The port can set or clear one PID, or wipe the whole table in one cycle. Clearing `cfg_filter_en` turns the table off, and every complete packet is then forwarded.

Top module: `tsf_pid_filter`

## Requirements
- R1: After reset `out_valid` is 0 and every table bit is 0, so with the filter enabled every packet is discarded until a PID is set.
- R2: An accepted packet leaves the block complete, with bytes unchanged and in arrival order, as one burst of consecutive `out_valid` cycles. `out_sop` is 1 on its first byte only. Packets leave in the order they arrived.
- R3: The PID is bit slice `[cfg_pid_lsb + cfg_pid_bits - 1 : cfg_pid_lsb]` of the 64-bit word {byte0, byte1, ..., byte7}, with byte0 in bits 63..56. Slice positions above bit 63 read as 0. The reset-time configuration used by a typical system is `cfg_pid_bits` = 13 and `cfg_pid_lsb` = 40, which takes the low 5 bits of byte1 and all of byte2.
- R4: With `cfg_filter_en` = 1, a packet is forwarded exactly when the table bit of its PID is 1. A cycle with `tbl_wr_en` = 1 writes `tbl_wr_set` into the bit of `tbl_wr_pid`, so 1 enables and 0 disables that PID alone.
- R5: With `cfg_filter_en` = 0 at decision time, every complete packet is forwarded whatever the table holds.
- R6: `tbl_clr_all` = 1 sets every table bit to 0 in one cycle. A single-bit write in the same cycle is applied on top of the clear.
- R7: A table write issued in the same cycle as byte index 7 (the eighth byte) or earlier applies to the packet in flight. A write issued with byte index 8 or later applies only from the next packet on.
- R8: A byte with `in_sop` = 1 that arrives before the current packet has all `PKT_LEN` bytes discards the partial packet, and that byte starts a new packet.
- R9: Bytes with `in_sop` = 0 that arrive while no packet is open, whether after reset or after a completed packet, are discarded and never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input byte |
| cfg_filter_en | input | 1 | 1: table decides; 0: all packets pass |
| cfg_pid_lsb | input | 6 | Lowest header-word bit of the PID field |
| cfg_pid_bits | input | 5 | Number of PID bits taken (up to PID_W) |
| tbl_wr_en | input | 1 | Write one table bit this cycle |
| tbl_wr_set | input | 1 | Value written: 1 enables, 0 disables the PID |
| tbl_wr_pid | input | PID_W | PID whose bit is written |
| tbl_clr_all | input | 1 | Clear the whole table this cycle |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | Output byte is the first of a packet |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the block with `PKT_LEN` = 16 and keeps the full 13-bit PID space and 32-bit table words. Short packets bring aborts both before and after the decision point, stray bytes, and many back-to-back decisions within a few thousand cycles. The full table keeps PID 0 and PID 0x1FFF, which sit at opposite ends of the word array, and neighbouring PIDs that share one word. The header-slice tests move `cfg_pid_lsb` to 0 and to 60 to reach both ends of the header word, including the zero fill above bit 63.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    // Header word assembled from the leading bytes of each packet
    localparam int HDR_BYTES = 8;
    localparam int HDR_W     = 8 * HDR_BYTES;

    // One stored byte of the packet ring
    typedef struct packed {
        logic       sop;
        logic [7:0] data;
    } tsf_beat_t;

    // Bit idx of the PID field: header bit (lsb + idx) when it exists and
    // idx is below the configured field width, zero otherwise.
    function automatic logic pid_bit_sel(
        input logic [HDR_W-1:0] hdr,
        input logic [5:0]       lsb,
        input logic [4:0]       nbits,
        input int unsigned      idx
    );
        logic [6:0] pos;
        pos = {1'b0, lsb} + 7'(idx);
        return (pos < 7'(HDR_W)) && (5'(idx) < nbits) && hdr[pos[5:0]];
    endfunction

endpackage

// File: rtl/tsf_hdr_capture.sv
module tsf_hdr_capture
    import tsf_pkg::*;
#(
    parameter int PKT_LEN = 188
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    output logic             acc,       // byte belongs to an open packet
    output logic             start,     // byte opens a new packet
    output logic             abort,     // new packet cuts an unfinished one
    output logic             last,      // byte completes the packet
    output logic             hdr_done,  // header word valid (one-cycle pulse)
    output logic [HDR_W-1:0] hdr_word
);

    localparam int CW = $clog2(PKT_LEN + 1);

    logic [CW-1:0] cnt;   // bytes received in the open packet, 0 = none open

    assign start = in_valid && in_sop;
    assign acc   = in_valid && (in_sop || cnt != '0);
    assign abort = start && cnt != '0;
    assign last  = acc && !start && cnt == CW'(PKT_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            hdr_word <= '0;
            hdr_done <= 1'b0;
        end else begin
            hdr_done <= acc && !start && cnt == CW'(HDR_BYTES - 1);
            if (start) begin
                cnt      <= CW'(1);
                hdr_word <= {{(HDR_W-8){1'b0}}, in_data};
            end else if (acc) begin
                cnt <= last ? '0 : cnt + CW'(1);
                if (cnt < CW'(HDR_BYTES))
                    hdr_word <= {hdr_word[HDR_W-9:0], in_data};
            end
        end
    end

    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> (cnt == CW'(1))) else $error("restart");   // R8

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && in_valid && !in_sop) |=> (cnt == '0)) else $error("stray"); // R9

endmodule

// File: rtl/tsf_pid_table.sv
module tsf_pid_table #(
    parameter int PID_W  = 13,
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_set,
    input  logic [PID_W-1:0] wr_pid,
    input  logic             clr_all,
    input  logic [PID_W-1:0] rd_pid,
    output logic             rd_hit
);

    localparam int BIT_W     = $clog2(WORD_W);
    localparam int IDX_W     = PID_W - BIT_W;
    localparam int NUM_WORDS = 2 ** IDX_W;

    logic [WORD_W-1:0] mem   [NUM_WORDS];
    logic [WORD_W-1:0] mem_d [NUM_WORDS];
    logic              any_set;

    wire [IDX_W-1:0] wr_idx = wr_pid[PID_W-1:BIT_W];
    wire [BIT_W-1:0] wr_bit = wr_pid[BIT_W-1:0];

    // Wipe first, then the single-bit write lands on top of it
    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++)
            mem_d[i] = clr_all ? '0 : mem[i];
        if (wr_en)
            mem_d[wr_idx][wr_bit] = wr_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++)
                mem[i] <= '0;
        end else begin
            mem <= mem_d;
        end
    end

    assign rd_hit = mem[rd_pid[PID_W-1:BIT_W]][rd_pid[BIT_W-1:0]];

    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < NUM_WORDS; i++)
            any_set = any_set | (|mem[i]);
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_set) |=>
        mem[$past(wr_pid[PID_W-1:BIT_W])][$past(wr_pid[BIT_W-1:0])]) else $error("set");   // R4

    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_set) |=>
        !mem[$past(wr_pid[PID_W-1:BIT_W])][$past(wr_pid[BIT_W-1:0])]) else $error("clr");  // R4

    AST_WIPE_ALL: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !wr_en) |=> !any_set) else $error("wipe");   // R6

endmodule

// File: rtl/tsf_pkt_store.sv
module tsf_pkt_store
    import tsf_pkg::*;
#(
    parameter int DEPTH = 376
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  tsf_beat_t wr_beat,
    input  logic      rollback,  // discard uncommitted bytes before this write
    input  logic      commit,    // publish all bytes up to and including this one
    input  logic      drop,      // discard uncommitted bytes including this one
    output logic      out_valid,
    output tsf_beat_t out_beat
);

    localparam int AW = $clog2(DEPTH);

    tsf_beat_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, cm_ptr, rd_ptr;
    logic [AW-1:0] base, wr_after;

    function automatic logic [AW-1:0] ring_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign base     = rollback ? cm_ptr : wr_ptr;
    assign wr_after = wr_en ? ring_next(base) : base;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[base] <= wr_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
        end else if (commit) begin
            wr_ptr <= wr_after;
            cm_ptr <= wr_after;
        end else if (drop) begin
            wr_ptr <= cm_ptr;
        end else begin
            wr_ptr <= wr_after;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr    <= '0;
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else if (rd_ptr != cm_ptr) begin
            rd_ptr    <= ring_next(rd_ptr);
            out_valid <= 1'b1;
            out_beat  <= mem[rd_ptr];
        end else begin
            out_valid <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ring_next(base) != rd_ptr)) else $error("overflow");   // R2

    AST_DROP_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (drop && !commit) |=> $stable(cm_ptr)) else $error("drop");   // R4

endmodule

// File: rtl/tsf_pid_filter.sv
module tsf_pid_filter
    import tsf_pkg::*;
#(
    parameter int PKT_LEN    = 188,
    parameter int PID_W      = 13,
    parameter int TBL_WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic             cfg_filter_en,
    input  logic [5:0]       cfg_pid_lsb,
    input  logic [4:0]       cfg_pid_bits,
    input  logic             tbl_wr_en,
    input  logic             tbl_wr_set,
    input  logic [PID_W-1:0] tbl_wr_pid,
    input  logic             tbl_clr_all,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_data
);

    localparam int STORE_DEPTH = 2 * PKT_LEN;

    logic             cap_acc, cap_start, cap_abort, cap_last, hdr_done;
    logic [HDR_W-1:0] hdr_word;
    logic [PID_W-1:0] look_pid;
    logic             tbl_hit;
    logic             keep_q;
    tsf_beat_t        in_beat, out_beat;

    tsf_hdr_capture #(.PKT_LEN(PKT_LEN)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_data  (in_data),
        .acc      (cap_acc),
        .start    (cap_start),
        .abort    (cap_abort),
        .last     (cap_last),
        .hdr_done (hdr_done),
        .hdr_word (hdr_word)
    );

    always_comb begin
        for (int i = 0; i < PID_W; i++)
            look_pid[i] = pid_bit_sel(hdr_word, cfg_pid_lsb, cfg_pid_bits, i);
    end

    tsf_pid_table #(.PID_W(PID_W), .WORD_W(TBL_WORD_W)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_set  (tbl_wr_set),
        .wr_pid  (tbl_wr_pid),
        .clr_all (tbl_clr_all),
        .rd_pid  (look_pid),
        .rd_hit  (tbl_hit)
    );

    // Decision is latched once per packet, the cycle after the header closes
    always_ff @(posedge clk) begin
        if (rst)
            keep_q <= 1'b0;
        else if (cap_start)
            keep_q <= 1'b0;
        else if (hdr_done)
            keep_q <= !cfg_filter_en || tbl_hit;
    end

    assign in_beat = '{sop: in_sop, data: in_data};

    tsf_pkt_store #(.DEPTH(STORE_DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cap_acc),
        .wr_beat   (in_beat),
        .rollback  (cap_abort),
        .commit    (cap_last && keep_q),
        .drop      (cap_last && !keep_q),
        .out_valid (out_valid),
        .out_beat  (out_beat)
    );

    assign out_sop  = out_valid && out_beat.sop;
    assign out_data = out_beat.data;

    AST_BYPASS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (hdr_done && !cfg_filter_en && !cap_start) |=> keep_q) else $error("bypass");   // R5

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid) else $error("reset");   // R1

endmodule

// File: tb/tb_tsf_pid_filter.sv
module tb_tsf_pid_filter;

    localparam int PKT   = 16;
    localparam int PID_W = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]       in_data = '0;
    logic             cfg_filter_en = 1'b1;
    logic [5:0]       cfg_pid_lsb = 6'd40;
    logic [4:0]       cfg_pid_bits = 5'd13;
    logic             tbl_wr_en = 1'b0, tbl_wr_set = 1'b0, tbl_clr_all = 1'b0;
    logic [PID_W-1:0] tbl_wr_pid = '0;
    logic             out_valid, out_sop;
    logic [7:0]       out_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic [8:0] exp_q[$];

    always #5 clk = ~clk;

    tsf_pid_filter #(.PKT_LEN(PKT), .PID_W(PID_W), .TBL_WORD_W(32)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_filter_en(cfg_filter_en), .cfg_pid_lsb(cfg_pid_lsb), .cfg_pid_bits(cfg_pid_bits),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_set(tbl_wr_set), .tbl_wr_pid(tbl_wr_pid),
        .tbl_clr_all(tbl_clr_all), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
    );

    // Output monitor: every beat must match the next expected one (R2, R4)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            logic [8:0] e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected output beat: actual %h expected none", {out_sop, out_data});
            end else begin
                e = exp_q.pop_front();
                if (e !== {out_sop, out_data}) begin
                    errors++;
                    $display("FAIL R2 output beat: actual %h expected %h", {out_sop, out_data}, e);
                end
            end
        end
    end

    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic [1:0]       op;    // 0 none, 1 set, 2 clear, 3 wipe table
        logic             en;
        logic             keep;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{13'h0100, 2'd0, 1'b1, 1'b0},   // R1 empty table drops
        '{13'h0100, 2'd1, 1'b1, 1'b1},   // R4 set -> kept
        '{13'h0101, 2'd0, 1'b1, 1'b0},   // R4 neighbour stays off
        '{13'h1FFF, 2'd1, 1'b1, 1'b1},   // R4 highest PID
        '{13'h0000, 2'd1, 1'b1, 1'b1},   // R4 lowest PID
        '{13'h0100, 2'd2, 1'b1, 1'b0},   // R4 clear -> dropped
        '{13'h0101, 2'd0, 1'b0, 1'b1},   // R5 bypass
        '{13'h1FFF, 2'd3, 1'b1, 1'b0},   // R6 wipe
        '{13'h0000, 2'd0, 1'b1, 1'b0},   // R6 wipe reached PID 0
        '{13'h0000, 2'd0, 1'b0, 1'b1}    // R5 bypass on empty table
    };

    function automatic logic [63:0] mkhdr(input logic [PID_W-1:0] pid);
        return {8'h47, 3'b000, pid[12:8], pid[7:0], 40'hC3_A5_5A_3C_96};
    endfunction

    task automatic tbl_op(input logic set, input logic wipe, input logic [PID_W-1:0] pid);
        @(negedge clk);
        tbl_wr_en   = !wipe;
        tbl_wr_set  = set;
        tbl_wr_pid  = pid;
        tbl_clr_all = wipe;
        @(negedge clk);
        tbl_wr_en   = 1'b0;
        tbl_clr_all = 1'b0;
    endtask

    // Sends nbytes of a packet; optionally sets PID inj_pid alongside byte inj_idx
    task automatic send_pkt(input logic [63:0] hdr, input logic [7:0] seed, input int nbytes,
                            input bit keep, input int inj_idx, input logic [PID_W-1:0] inj_pid);
        logic [8:0] beats [PKT];
        for (int i = 0; i < PKT; i++)
            beats[i] = {i == 0, (i < 8) ? hdr[63 - 8*i -: 8] : seed + 8'(i)};
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_sop     = beats[i][8];
            in_data    = beats[i][7:0];
            tbl_wr_en  = (i == inj_idx);
            tbl_wr_set = 1'b1;
            tbl_wr_pid = inj_pid;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_sop    = 1'b0;
        tbl_wr_en = 1'b0;
        if (keep && nbytes == PKT)
            for (int i = 0; i < PKT; i++) exp_q.push_back(beats[i]);
    endtask

    task automatic drain(input string tag);
        repeat (PKT + 4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s pending beats: actual %0d expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid after reset: actual %b expected 0", out_valid);
        end

        // Vector table walk (R1 R4 R5 R6)
        for (int v = 0; v < NV; v++) begin
            case (VEC[v].op)
                2'd1: tbl_op(1'b1, 1'b0, VEC[v].pid);
                2'd2: tbl_op(1'b0, 1'b0, VEC[v].pid);
                2'd3: tbl_op(1'b0, 1'b1, '0);
                default: ;
            endcase
            cfg_filter_en = VEC[v].en;
            send_pkt(mkhdr(VEC[v].pid), 8'(v * 16), PKT, VEC[v].keep, -1, '0);
            drain("R4 vector");
        end
        cfg_filter_en = 1'b1;

        // R3: field at the bottom of the header word (byte7)
        cfg_pid_lsb = 6'd0; cfg_pid_bits = 5'd8;
        tbl_op(1'b1, 1'b0, 13'h005A);
        send_pkt({8'h47, 48'h0, 8'h5A}, 8'h10, PKT, 1'b1, -1, '0);
        send_pkt({8'h47, 48'h0, 8'h5B}, 8'h20, PKT, 1'b0, -1, '0);
        drain("R3 low field");
        // R3: field straddling bit 63, upper bits read as zero
        cfg_pid_lsb = 6'd60;
        tbl_op(1'b1, 1'b0, 13'h0004);
        send_pkt({8'h47, 56'h0}, 8'h30, PKT, 1'b1, -1, '0);
        send_pkt({8'h57, 56'h0}, 8'h40, PKT, 1'b0, -1, '0);
        drain("R3 top field");
        cfg_pid_lsb = 6'd40; cfg_pid_bits = 5'd13;
        tbl_op(1'b0, 1'b1, '0);

        // R7: write alongside byte index 8 is too late, next packet sees it
        send_pkt(mkhdr(13'h0ABC), 8'h50, PKT, 1'b0, 8, 13'h0ABC);
        send_pkt(mkhdr(13'h0ABC), 8'h60, PKT, 1'b1, -1, '0);
        drain("R7 late write");
        // R7: write alongside byte index 7 still counts
        send_pkt(mkhdr(13'h0ABD), 8'h70, PKT, 1'b1, 7, 13'h0ABD);
        drain("R7 early write");

        // R8: abort before and after the decision point
        send_pkt(mkhdr(13'h0ABC), 8'h80, 5, 1'b1, -1, '0);
        send_pkt(mkhdr(13'h0ABC), 8'h90, PKT, 1'b1, -1, '0);
        send_pkt(mkhdr(13'h0ABC), 8'hA0, PKT - 2, 1'b1, -1, '0);
        send_pkt(mkhdr(13'h0ABD), 8'hB0, PKT, 1'b1, -1, '0);
        drain("R8 abort");

        // R9: stray bytes outside a packet are discarded
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_data = 8'(8'hE0 + i);
        end
        @(negedge clk); in_valid = 1'b0;
        drain("R9 stray");
        send_pkt(mkhdr(13'h0ABC), 8'hC0, PKT, 1'b1, -1, '0);
        drain("R9 after stray");

        // R2: back-to-back kept packets in arrival order
        send_pkt(mkhdr(13'h0ABC), 8'hD0, PKT, 1'b1, -1, '0);
        send_pkt(mkhdr(13'h0ABD), 8'hE0, PKT, 1'b1, -1, '0);
        drain("R2 order");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule